// File: doc/BRIEF.md
# Shared GPIO Port with Analog-Channel Override

This block is an eight-pin bidirectional port. Each pin doubles as an input channel of an analog converter that sits elsewhere. Software reaches the port through a small register bus. It can set an output data register and a direction register, read back the port, and write a five-bit channel-select value that names the converter input in use.

When the channel select names a channel from 0 to 7, the port pin of that number belongs to the converter. The port stops driving that pin: its output enable is held low and its output data is held low. A port read shows zero in that bit position. Writes still land in the data and direction registers for that pin, and the stored values take effect as soon as the channel select moves to a different value. Channel values from 8 to 31 claim no pin. The value 31 means the converter is off.

Pad inputs pass through a two-flop synchroniser before software can see them. A pin set as output reads back its data-register bit. A pin set as input reads back its synchronised pad level.

Top module: `shared_gpio_port`

## Requirements
- R1: After reset the data and direction registers are zero, every pad_oe bit and every pad_out bit is 0, and the channel select reads 31.
- R2: A bus write to address 1 stores the direction byte, which reads back from address 1. A write to address 0 stores the data byte. Both registers store the full byte even for an overridden pin.
- R3: For a pin that is not overridden, pad_oe equals its direction bit (1 = output) and pad_out equals its data bit.
- R4: When the channel select holds a value c from 0 to 7, pad_oe[c] and pad_out[c] are 0, whatever the data and direction registers hold.
- R5: A read of address 0 returns 0 in bit c while channel c (0 to 7) is selected.
- R6: Channel-select values 8 to 31 override no pin.
- R7: When the channel select leaves a pin, the stored direction and data for that pin drive pad_oe and pad_out from the next cycle.
- R8: For a pin set as input, a read of address 0 shows the pad level sampled two clock edges earlier, and not a level that has passed only one edge.
- R9: For a pin set as output and not overridden, a read of address 0 returns its data-register bit regardless of the pad level.
- R10: A write to address 2 keeps only the low five bits as the channel select, and a read of address 2 returns that value with bits 7 to 5 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 port/data, 1 direction, 2 channel select |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 8 | Levels seen at the pins |
| pad_out | output | 8 | Output data to the pins |
| pad_oe | output | 8 | Output enable per pin, 1 = drive |

## Verification
The hardest case is one where the override hides a pin whose registers would otherwise drive it or show it, and then releases that pin. That needs every channel value combined with direction, data and pad patterns whose bits disagree at the claimed position. The bench therefore sweeps all 32 channel-select values. Under each value it applies four mixed direction/data/pad byte patterns and compares the enables, the outputs and the port read with a bench-side model. It then moves the channel select off a fully configured pin and checks that the stored settings appear in the next cycle. A separate step changes the pad level and reads the port after one edge and after two edges to check the synchroniser delay.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned PORT_PINS = 8;
  localparam int unsigned CH_W      = 5;
  localparam int unsigned ADR_W     = 2;

  localparam logic [ADR_W-1:0] ADR_PORT  = 2'd0;
  localparam logic [ADR_W-1:0] ADR_DIR   = 2'd1;
  localparam logic [ADR_W-1:0] ADR_CHSEL = 2'd2;

  // Channel value that means the converter is off
  localparam logic [CH_W-1:0] CH_OFF = '1;

  // One-hot pin mask claimed by a channel value (zero above the pin range)
  function automatic logic [PORT_PINS-1:0] claim_mask(input logic [CH_W-1:0] ch);
    logic [PORT_PINS-1:0] m;
    m = '0;
    for (int i = 0; i < int'(PORT_PINS); i++) begin
      if (int'(ch) == i) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Port read: output pins show data, input pins show synced pad, claimed pins zero
  function automatic logic [PORT_PINS-1:0] port_view(
      input logic [PORT_PINS-1:0] data,
      input logic [PORT_PINS-1:0] dir,
      input logic [PORT_PINS-1:0] synced,
      input logic [PORT_PINS-1:0] claim);
    return ((dir & data) | (~dir & synced)) & ~claim;
  endfunction
endpackage

// File: rtl/ovr_decode.sv
module ovr_decode #(
  parameter int unsigned PINS = gpio_ovr_pkg::PORT_PINS,
  parameter int unsigned CHW  = gpio_ovr_pkg::CH_W
) (
  input  logic [CHW-1:0]  ch,
  output logic [PINS-1:0] claim
);
  genvar g;
  generate
    for (g = 0; g < PINS; g++) begin : g_pin
      assign claim[g] = (ch == CHW'(g));
    end
  endgenerate

  // R6 - at most one pin claimed, and none for values outside the pin range
  always_comb begin
    ovr_count_chk: assert ($countones(claim) == ((int'(ch) < int'(PINS)) ? 1 : 0));
  end
endmodule

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int unsigned W = gpio_ovr_pkg::PORT_PINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [1:0]   age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R8
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/port_regs.sv
module port_regs #(
  parameter int unsigned PINS = gpio_ovr_pkg::PORT_PINS,
  parameter int unsigned CHW  = gpio_ovr_pkg::CH_W,
  parameter int unsigned AW   = gpio_ovr_pkg::ADR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] data_q,
  output logic [PINS-1:0] dir_q,
  output logic [CHW-1:0]  ch_q
);
  import gpio_ovr_pkg::*;

  logic wr_data, wr_dir, wr_ch;
  assign wr_data = wr && (addr == ADR_PORT);
  assign wr_dir  = wr && (addr == ADR_DIR);
  assign wr_ch   = wr && (addr == ADR_CHSEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      ch_q   <= CH_OFF;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
      if (wr_ch)   ch_q   <= wdata[CHW-1:0];
    end
  end
endmodule

// File: rtl/shared_gpio_port.sv
module shared_gpio_port #(
  parameter int unsigned PINS = gpio_ovr_pkg::PORT_PINS,
  parameter int unsigned CHW  = gpio_ovr_pkg::CH_W,
  parameter int unsigned AW   = gpio_ovr_pkg::ADR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  import gpio_ovr_pkg::*;

  localparam int unsigned IDXW = $clog2(PINS);

  logic [PINS-1:0] data_q, dir_q, synced, claim;
  logic [CHW-1:0]  ch_q;

  port_regs #(.PINS(PINS), .CHW(CHW), .AW(AW)) i_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .ch_q(ch_q)
  );

  ovr_decode #(.PINS(PINS), .CHW(CHW)) i_decode (
    .ch(ch_q), .claim(claim)
  );

  pad_sync #(.W(PINS)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(synced)
  );

  assign pad_oe  = dir_q  & ~claim;
  assign pad_out = data_q & ~claim;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_PORT:  bus_rdata = port_view(data_q, dir_q, synced, claim);
      ADR_DIR:   bus_rdata = dir_q;
      ADR_CHSEL: bus_rdata[CHW-1:0] = ch_q;
      default:   bus_rdata = '0;
    endcase
  end

  // R4
  ovr_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ch_q) < int'(PINS)) |-> (!pad_oe[ch_q[IDXW-1:0]] && !pad_out[ch_q[IDXW-1:0]]));

  // R5
  ovr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_PORT) |-> ((bus_rdata & claim) == '0));
endmodule

// File: tb/test_shared_gpio_port.sv
module test_shared_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  shared_gpio_port i_shared_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] mask_of(input int ch);
    return (ch < 8) ? (8'h01 << ch) : 8'h00;
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, m, dv, da, pv, e;
    logic [7:0] dirs [4] = '{8'h00, 8'hFF, 8'h0F, 8'hA5};
    logic [7:0] dats [4] = '{8'hFF, 8'h5A, 8'hC3, 8'h3C};
    logic [7:0] pins [4] = '{8'hA5, 8'h0F, 8'hFF, 8'h96};

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    rd(2'd1, v); check("R1 dir", v, 8'h00);
    rd(2'd2, v); check("R1 chsel", v, 8'h1F);
    @(negedge clk); rst_n = 1'b1;

    for (int ch = 0; ch < 32; ch++) begin
      wr(2'd2, 8'hE0 | 8'(ch));
      rd(2'd2, v); check("R10 chsel readback", v, 8'(ch));
      m = mask_of(ch);
      for (int k = 0; k < 4; k++) begin
        dv = dirs[k]; da = dats[k]; pv = pins[k] ^ 8'(ch);
        @(negedge clk); pad_in = pv;
        wr(2'd1, dv);
        wr(2'd0, da);
        rd(2'd1, v); check("R2 dir stored", v, dv);
        e = dv & ~m;
        check(ch < 8 ? "R4 pad_oe" : "R3 R6 pad_oe", pad_oe, e);
        e = da & ~m;
        check(ch < 8 ? "R4 pad_out" : "R3 R6 pad_out", pad_out, e);
        e = ((dv & da) | (~dv & pv)) & ~m;
        rd(2'd0, v);
        check(ch < 8 ? "R5 R8 R9 port read" : "R6 R8 R9 port read", v, e);
      end
    end

    // R7 release of a claimed pin
    wr(2'd2, 8'd3);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hAA);
    check("R7 claimed oe", pad_oe, 8'hF7);
    check("R7 claimed out", pad_out, 8'hA2);
    wr(2'd2, 8'd31);
    check("R7 released oe", pad_oe, 8'hFF);
    check("R7 released out", pad_out, 8'hAA);
    rd(2'd0, v); check("R9 output read ignores pad", v, 8'hAA);

    // R8 synchroniser latency
    wr(2'd1, 8'h00);
    @(negedge clk); pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h5C;
    @(negedge clk);
    rd(2'd0, v); check("R8 one edge old", v, 8'h00);
    @(negedge clk);
    rd(2'd0, v); check("R8 two edges new", v, 8'h5C);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule